// File: doc/BRIEF.md
# Multi-Port Receive Cell Source

This block sits on the physical-layer side of a shared receive cell bus. It delivers cells from several line ports to one ATM-layer device over one 8-bit data path. Each port sets a ready flag when a complete 53-byte cell has been loaded into its buffer. The buffer itself lives outside the block and is read through a simple combinational fetch interface: the block presents a port number and a byte index, and the byte comes back in the same cycle.

The ATM layer polls a port by driving its 5-bit bus address. One clock later the block drives a cell-available bit for that address, together with an output-enable for the pad. To select a port, the ATM layer holds its address on the last cycle that the active-low enable is high, then pulls the enable low. Each clock with the enable low moves one byte onto the bus. Each byte comes with an odd-parity bit, and the first byte of a cell is flagged with start-of-cell. Raising the enable freezes the bus. The next low enable resumes the same cell.

The cell-available line is not tri-stated inside the block. A separate enable output tells the pad ring when this device may drive the shared line.

Top module: `rx_cell_source`

## Requirements
- R1: While reset is asserted, rx_data is 0, rx_prty is 1, rx_soc is 0, and rx_clav and rx_clav_oe are 0.
- R2: Port i's bus address is bits 4:0 of its slice port_addr_cfg[5*i +: 5]. One clock after rx_addr equals a port's address, rx_clav_oe is 1 and rx_clav equals that port's ready flag.
- R3: One clock after rx_addr matches no port's address, rx_clav_oe and rx_clav are both 0.
- R4: A one-cycle pulse on cell_load[i] sets port i's ready flag. The flag clears when the 53rd byte (index 52) of that port's cell is sent.
- R5: The selected port is the one addressed on the last clock where rx_enb is high, before a clock where rx_enb is low. If that port is ready, byte 0 appears on rx_data with rx_soc = 1 after that first low-enable clock.
- R6: Each clock with rx_enb low during a cell puts the next byte on rx_data, in index order 0 to 52, fetched as fetch_byte while fetch_port and fetch_idx name the port and index. rx_soc is 0 for every byte except index 0.
- R7: A clock with rx_enb high leaves rx_data, rx_prty and rx_soc unchanged and does not advance the byte index. The next low enable continues the same cell, whatever address is driven during the pause.
- R8: For every bus value, the 8 bits of rx_data plus rx_prty contain an odd number of ones.
- R9: Selecting a port that is not ready, or an address that matches no port, sends no byte. rx_data holds its value and rx_soc stays 0.
- R10: After byte 52, further low-enable clocks send nothing and the bus holds. A new cell needs a new selection (enable high, then low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr_cfg | input | 20 | Per-port bus address, 5 bits per port, port 0 in the low bits |
| cell_load | input | 4 | Per-port pulse: a full cell is now in the buffer |
| fetch_port | output | 2 | Port whose buffer is read this cycle |
| fetch_idx | output | 6 | Byte index read this cycle |
| fetch_byte | input | 8 | Buffer byte for fetch_port/fetch_idx, same cycle |
| rx_addr | input | 5 | Poll and select address from the ATM layer |
| rx_enb | input | 1 | Active-low transfer enable from the ATM layer |
| rx_data | output | 8 | Cell byte |
| rx_prty | output | 1 | Odd parity over rx_data |
| rx_soc | output | 1 | High with the first byte of a cell |
| rx_clav | output | 1 | Cell available for the polled port |
| rx_clav_oe | output | 1 | Pad drive enable for rx_clav |

## Verification
A wrong byte index or port latch shows up as a wrong or repeated data byte, or as a misplaced start-of-cell. This appears at the first low-enable clock after the fault, and the bench catches it because it compares every bus cycle in order. A ready flag that fails to clear or to set shows up at the next poll of that address as a wrong cell-available bit, one clock after the address. A sequencer that advances during a pause, or that ignores a resume, breaks the expected hold value or the byte order within one cycle of the enable change.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_XFER = 1'b1
  } sq_state_e;

  localparam int unsigned DEF_CELL_BYTES = 53;
endpackage

// File: rtl/rxs_ready_flags.sv
module rxs_ready_flags #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] load,
  input  logic [NUM_PORTS-1:0] clr,
  output logic [NUM_PORTS-1:0] rdy
);
  logic [NUM_PORTS-1:0] rdy_q;
  logic [NUM_PORTS-1:0] rdy_d;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_flag
    // a new load wins over a same-cycle clear
    always_comb begin
      rdy_d[g] = rdy_q[g];
      if (clr[g])  rdy_d[g] = 1'b0;
      if (load[g]) rdy_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_q[g] <= 1'b0;
      else        rdy_q[g] <= rdy_d[g];
    end

    // R4
    rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !load[g]) |=> !rdy_q[g]);
    // R4
    rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load[g] |=> rdy_q[g]);
  end

  assign rdy = rdy_q;
endmodule

// File: rtl/rxs_addr_match.sv
module rxs_addr_match #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 5,
  localparam int unsigned PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*ADDR_W-1:0] cfg,
  input  logic [ADDR_W-1:0]           rx_addr,
  input  logic [NUM_PORTS-1:0]        rdy,
  output logic                        hit_q,
  output logic [PW-1:0]               midx_q,
  output logic                        clav_q,
  output logic                        clav_oe_q
);
  logic [NUM_PORTS-1:0] match;
  logic                 hit_d;
  logic [PW-1:0]        midx_d;
  logic                 clav_d;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_cmp
    assign match[g] = (cfg[g*ADDR_W +: ADDR_W] == rx_addr);
  end

  // lowest port index wins on duplicate addresses
  always_comb begin
    hit_d  = 1'b0;
    midx_d = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_d  = 1'b1;
        midx_d = PW'(i);
      end
    end
    clav_d = hit_d && rdy[midx_d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q     <= 1'b0;
      midx_q    <= '0;
      clav_q    <= 1'b0;
      clav_oe_q <= 1'b0;
    end else begin
      hit_q     <= hit_d;
      midx_q    <= midx_d;
      clav_q    <= clav_d;
      clav_oe_q <= hit_d;
    end
  end

  // R3
  clav_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clav_q |-> clav_oe_q);
  // R2
  clav_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clav_oe_q && !clav_q) |-> !rdy[$past(midx_d)] || $past(!hit_d) || $past(|(~rdy & rdy)) || !$past(rdy[midx_d]));
endmodule

// File: rtl/rxs_byte_seq.sv
module rxs_byte_seq
  import rxs_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = DEF_CELL_BYTES,
  localparam int unsigned PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned IW        = $clog2(CELL_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_enb,
  input  logic                 hit_q,
  input  logic [PW-1:0]        midx_q,
  input  logic [NUM_PORTS-1:0] rdy,
  input  logic [DATA_W-1:0]    fetch_byte,
  output logic [PW-1:0]        fetch_port,
  output logic [IW-1:0]        fetch_idx,
  output logic [NUM_PORTS-1:0] clr,
  output logic [DATA_W-1:0]    rx_data,
  output logic                 rx_prty,
  output logic                 rx_soc
);
  localparam logic [IW-1:0] LAST_IDX = IW'(CELL_BYTES - 1);

  sq_state_e         st_q, st_d;
  logic              enb_q;
  logic [PW-1:0]     sel_q, sel_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              soc_q, soc_d;
  logic              prty_q, prty_d;
  logic              start, send, last;
  logic [PW-1:0]     cur_port;
  logic [IW-1:0]     cur_idx;

  always_comb begin
    start    = (st_q == SQ_IDLE) && enb_q && !rx_enb && hit_q && rdy[midx_q];
    send     = !rx_enb && (start || (st_q == SQ_XFER));
    cur_port = start ? midx_q : sel_q;
    cur_idx  = start ? '0 : idx_q;
    last     = send && (cur_idx == LAST_IDX);
  end

  assign fetch_port = cur_port;
  assign fetch_idx  = cur_idx;

  // next state for the sequencer
  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    data_d = data_q;
    soc_d  = soc_q;
    prty_d = prty_q;
    clr    = '0;
    if (send) begin
      data_d = fetch_byte;
      soc_d  = (cur_idx == '0);
      prty_d = ~^fetch_byte;
      sel_d  = cur_port;
      if (last) begin
        st_d          = SQ_IDLE;
        idx_d         = '0;
        clr[cur_port] = 1'b1;
      end else begin
        st_d  = SQ_XFER;
        idx_d = cur_idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb_q <= 1'b1;
      st_q  <= SQ_IDLE;
    end else begin
      enb_q <= rx_enb;
      st_q  <= st_d;
    end
  end

  // byte-path registers, clock-enabled by send
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      idx_q  <= '0;
      data_q <= '0;
      soc_q  <= 1'b0;
      prty_q <= 1'b1;
    end else if (send) begin
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      soc_q  <= soc_d;
      prty_q <= prty_d;
    end
  end

  assign rx_data = data_q;
  assign rx_prty = prty_q;
  assign rx_soc  = soc_q;

  // R8
  parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (^{data_q, prty_q}) == 1'b1);
  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enb |=> ($stable(data_q) && $stable(soc_q) && $stable(idx_q)));
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IW'(CELL_BYTES));
  // R5
  soc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_q && !$past(soc_q)) |-> $past(!rx_enb));
  // R4
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
endmodule

// File: rtl/rx_cell_source.sv
module rx_cell_source #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 53,
  localparam int unsigned PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned IW        = $clog2(CELL_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*ADDR_W-1:0] port_addr_cfg,
  input  logic [NUM_PORTS-1:0]        cell_load,
  output logic [PW-1:0]               fetch_port,
  output logic [IW-1:0]               fetch_idx,
  input  logic [DATA_W-1:0]           fetch_byte,
  input  logic [ADDR_W-1:0]           rx_addr,
  input  logic                        rx_enb,
  output logic [DATA_W-1:0]           rx_data,
  output logic                        rx_prty,
  output logic                        rx_soc,
  output logic                        rx_clav,
  output logic                        rx_clav_oe
);
  logic [NUM_PORTS-1:0] rdy;
  logic [NUM_PORTS-1:0] clr;
  logic                 hit_q;
  logic [PW-1:0]        midx_q;

  rxs_ready_flags #(.NUM_PORTS(NUM_PORTS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cell_load),
    .clr  (clr),
    .rdy  (rdy)
  );

  rxs_addr_match #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (port_addr_cfg),
    .rx_addr  (rx_addr),
    .rdy      (rdy),
    .hit_q    (hit_q),
    .midx_q   (midx_q),
    .clav_q   (rx_clav),
    .clav_oe_q(rx_clav_oe)
  );

  rxs_byte_seq #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W),
    .CELL_BYTES(CELL_BYTES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enb    (rx_enb),
    .hit_q     (hit_q),
    .midx_q    (midx_q),
    .rdy       (rdy),
    .fetch_byte(fetch_byte),
    .fetch_port(fetch_port),
    .fetch_idx (fetch_idx),
    .clr       (clr),
    .rx_data   (rx_data),
    .rx_prty   (rx_prty),
    .rx_soc    (rx_soc)
  );
endmodule

// File: tb/rx_cell_source_bench.sv
module rx_cell_source_bench;
  typedef struct {
    logic [7:0] d;
    logic       s;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] port_addr_cfg;
  logic [3:0]  cell_load;
  logic [1:0]  fetch_port;
  logic [5:0]  fetch_idx;
  logic [7:0]  fetch_byte;
  logic [4:0]  rx_addr;
  logic        rx_enb;
  logic [7:0]  rx_data;
  logic        rx_prty, rx_soc, rx_clav, rx_clav_oe;

  int   checks = 0;
  int   fails  = 0;
  int   gen [4];
  exp_t q[$];
  logic [7:0] last_d;
  logic       last_s;

  always #5 clk = ~clk;

  function automatic logic [7:0] mkbyte(input int p, input int i, input int g);
    return 8'((p << 6) ^ i ^ (g * 29));
  endfunction

  function automatic logic [4:0] paddr(input int p);
    return port_addr_cfg[p*5 +: 5];
  endfunction

  assign fetch_byte = mkbyte(int'(fetch_port), int'(fetch_idx), gen[fetch_port]);

  rx_cell_source u_rx_cell_source (
    .clk(clk), .rst_n(rst_n), .port_addr_cfg(port_addr_cfg), .cell_load(cell_load),
    .fetch_port(fetch_port), .fetch_idx(fetch_idx), .fetch_byte(fetch_byte),
    .rx_addr(rx_addr), .rx_enb(rx_enb), .rx_data(rx_data), .rx_prty(rx_prty),
    .rx_soc(rx_soc), .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic s, input string req);
    exp_t e;
    e.d = d; e.s = s; e.req = req;
    q.push_back(e);
    last_d = d; last_s = s;
  endtask

  // monitor: one expected bus value per clock while items are queued
  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " data"}, 32'(rx_data), 32'(e.d));
      chk({e.req, " soc"},  32'(rx_soc),  32'(e.s));
      chk("R8 parity", 32'(rx_prty), 32'(~^e.d));
    end
  end

  task automatic poll(input logic [4:0] a, input logic oe, input logic cv, input string req);
    @(negedge clk);
    rx_addr = a; rx_enb = 1'b1;
    @(posedge clk); #3;
    chk({req, " clav_oe"}, 32'(rx_clav_oe), 32'(oe));
    chk({req, " clav"},    32'(rx_clav),    32'(cv));
  endtask

  task automatic load(input int p);
    @(negedge clk);
    cell_load[p] = 1'b1; gen[p]++;
    @(negedge clk);
    cell_load = '0;
  endtask

  // R5 R6 R7 R10: full cell with one pause and trailing low-enable clocks
  task automatic xfer(input int p, input int pause_at, input int pause_len, input int extra);
    @(negedge clk);
    rx_addr = paddr(p); rx_enb = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 53; i++) begin
      if (i == pause_at) begin
        for (int k = 0; k < pause_len; k++) begin
          rx_enb = 1'b1; rx_addr = 5'h1F;
          push(last_d, last_s, "R7 pause");
          @(negedge clk);
        end
      end
      rx_enb = 1'b0;
      push(mkbyte(p, i, gen[p]), (i == 0), (i == 0) ? "R5 first" : "R6 byte");
      @(negedge clk);
    end
    for (int k = 0; k < extra; k++) begin
      rx_enb = 1'b0;
      push(last_d, 1'b0, "R10 after last");
      @(negedge clk);
    end
    rx_enb = 1'b1;
    wait (q.size() == 0);
  endtask

  // R9: selection of a non-ready or unmatched address
  task automatic sel_empty(input logic [4:0] a, input int n);
    @(negedge clk);
    rx_addr = a; rx_enb = 1'b1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      rx_enb = 1'b0;
      push(last_d, 1'b0, "R9 empty");
      @(negedge clk);
    end
    rx_enb = 1'b1;
    wait (q.size() == 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) gen[i] = 0;
    port_addr_cfg = {5'h1C, 5'h11, 5'h0A, 5'h03};
    cell_load = '0; rx_addr = 5'h1F; rx_enb = 1'b1;
    last_d = 8'h00; last_s = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 data", 32'(rx_data), 32'h0);
    chk("R1 parity", 32'(rx_prty), 32'h1);
    chk("R1 soc", 32'(rx_soc), 32'h0);
    chk("R1 clav", 32'(rx_clav), 32'h0);
    chk("R1 clav_oe", 32'(rx_clav_oe), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    poll(5'h03, 1'b1, 1'b0, "R2 empty port");
    poll(5'h05, 1'b0, 1'b0, "R3 unmatched");
    load(1);
    poll(5'h0A, 1'b1, 1'b1, "R4 set");
    poll(5'h1C, 1'b1, 1'b0, "R2 other port");
    xfer(1, 10, 3, 2);
    poll(5'h0A, 1'b1, 1'b0, "R4 clear");
    sel_empty(5'h03, 3);
    sel_empty(5'h05, 2);
    load(2);
    load(3);
    poll(5'h11, 1'b1, 1'b1, "R2 port2 ready");
    xfer(3, 52, 2, 1);
    xfer(2, 1, 2, 0);
    poll(5'h11, 1'b1, 1'b0, "R4 clear port2");
    poll(5'h1C, 1'b1, 1'b0, "R4 clear port3");
    load(1);
    xfer(1, 30, 4, 3);
    poll(5'h0A, 1'b1, 1'b0, "R4 clear again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule